// File: doc/BRIEF.md
# Dual-Channel UART Register Access Controller

This block sits between a simple parallel host bus and the two register banks of a dual-channel UART. It decodes the host address, the channel-select input and the read and write strobes, and turns them into per-channel write and read enables, a shared register index and write data. Each channel reports three flags to the controller: its divisor-latch access bit, its enhanced-feature enable, and whether both integer divisor bytes are zero. The controller uses the selected channel's flags to choose between the normal registers, the divisor bytes and the fractional divisor register.

The controller holds one register shared by both channels, the alternate-function register. Its bit 0 turns on concurrent writes: one host write then strobes every channel with the same index and data. Reads are always steered by channel select. Bits 2:1 choose which active-low source each channel drives on its multifunction pin. A read-only identification register returns a fixed code while the selected channel's divisor is zero.

Top module: `dual_uart_regctl`

## Requirements
- R1: After reset the alternate-function register is 0. Reading it returns 0x00, and each `mf_n` pin follows that channel's `src_op2_n`.
- R2: While alternate-function bit 0 is 0, a host write asserts `ch_we` only for the channel named by `cpu_chsel`.
- R3: While alternate-function bit 0 is 1, a host write to a channel register asserts `ch_we` for every channel, with the same `ch_reg` and `ch_wdata`.
- R4: A host read asserts `ch_re` only for the selected channel and returns that channel's `ch_rdata` byte, also in concurrent mode.
- R5: The alternate-function register is at address 4 with the access bit set. Either channel can write it, and the write takes effect at the next clock edge. Only bits 2:0 are stored, so bits 7:3 read 0.
- R6: Alternate-function bits 2:1 pick the source for `mf_n`: 0 gives `src_op2_n`, 1 gives `src_baud_n`, 2 holds the pin high, and 3 gives `src_rxrdy_n`.
- R7: With the access bit set, address 2 maps to index 10 (fractional divisor) only when the selected channel's `ch_enh` is 1. Otherwise it maps to index 2.
- R8: With the access bit set and the selected channel's `ch_divz` at 1, address 5 is the identification register. A read returns `DEV_ID` (0x02) with no `ch_re`. A write to it changes nothing and asserts no `ch_we`. With `ch_divz` at 0, address 5 goes to channel index 5.
- R9: With the access bit clear, `ch_reg` equals the address (0 to 7). With it set, address 0 maps to index 8 (divisor low) and address 1 maps to index 9 (divisor high).
- R10: An access to the alternate-function register asserts neither `ch_we` nor `ch_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 3 | Host register address |
| cpu_chsel | input | $clog2(NUM_CH) | Channel select |
| cpu_wr | input | 1 | Host write strobe |
| cpu_rd | input | 1 | Host read strobe |
| cpu_wdata | input | 8 | Host write data |
| cpu_rdata | output | 8 | Host read data |
| ch_dlab | input | NUM_CH | Divisor-latch access bit of each channel |
| ch_enh | input | NUM_CH | Enhanced-feature enable of each channel |
| ch_divz | input | NUM_CH | Both integer divisor bytes zero, per channel |
| ch_rdata | input | 8*NUM_CH | Read data of each channel, channel 0 in the low byte |
| ch_we | output | NUM_CH | Per-channel register write enable |
| ch_re | output | NUM_CH | Per-channel register read enable |
| ch_reg | output | 4 | Register index for the channels |
| ch_wdata | output | 8 | Write data to the channels |
| src_op2_n | input | NUM_CH | General-purpose output source, active low |
| src_baud_n | input | NUM_CH | Baud clock output source, active low |
| src_rxrdy_n | input | NUM_CH | Receive-ready source, active low |
| mf_n | output | NUM_CH | Multifunction pin of each channel, active low |

## Verification
The bench builds the block with its defaults: two channels and identification code 0x02. With two channels, a single-bit select reaches every steering case, so each concurrent write can be compared against a single-channel write. The three pin sources are driven with different patterns on the two channels, so each select code gives a distinct expected pin pair. Each decode case runs with the access, enhanced-feature and zero-divisor flags both set and cleared.

// File: rtl/dca_pkg.sv
package dca_pkg;

    localparam int IDX_W = 4;
    localparam int DAT_W = 8;

    localparam logic [IDX_W-1:0] IDX_DIV_LO  = 4'd8;
    localparam logic [IDX_W-1:0] IDX_DIV_HI  = 4'd9;
    localparam logic [IDX_W-1:0] IDX_DIV_FRC = 4'd10;

    localparam logic [2:0] ADR_DIV_LO  = 3'd0;
    localparam logic [2:0] ADR_DIV_HI  = 3'd1;
    localparam logic [2:0] ADR_DIV_FRC = 3'd2;
    localparam logic [2:0] ADR_ALTFN   = 3'd4;
    localparam logic [2:0] ADR_IDENT   = 3'd5;

    typedef enum logic [1:0] {
        MF_GPO   = 2'd0,
        MF_BAUD  = 2'd1,
        MF_OFF   = 2'd2,
        MF_RXRDY = 2'd3
    } mf_sel_e;

    typedef struct packed {
        logic             hit_altfn;
        logic             hit_ident;
        logic [IDX_W-1:0] idx;
    } dec_t;

    function automatic logic mf_pick(input mf_sel_e sel, input logic gpo_n,
                                     input logic baud_n, input logic rxr_n);
        case (sel)
            MF_GPO:   return gpo_n;
            MF_BAUD:  return baud_n;
            MF_RXRDY: return rxr_n;
            default:  return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/dca_decode.sv
module dca_decode
    import dca_pkg::*;
(
    input  logic [2:0] addr,
    input  logic       dlab,
    input  logic       enh,
    input  logic       divz,
    output dec_t       dec
);
    always_comb begin
        dec.hit_altfn = 1'b0;
        dec.hit_ident = 1'b0;
        dec.idx       = {1'b0, addr};
        if (dlab) begin
            case (addr)
                ADR_DIV_LO:  dec.idx = IDX_DIV_LO;
                ADR_DIV_HI:  dec.idx = IDX_DIV_HI;
                ADR_DIV_FRC: if (enh) dec.idx = IDX_DIV_FRC;
                ADR_ALTFN:   dec.hit_altfn = 1'b1;
                ADR_IDENT:   if (divz) dec.hit_ident = 1'b1;
                default:     ;
            endcase
        end
    end
endmodule

// File: rtl/dca_altfn.sv
module dca_altfn
    import dca_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [2:0] wdata,
    output logic [2:0] afr_q,
    output logic       concur,
    output mf_sel_e    mf_sel
);
    always_ff @(posedge clk) begin
        if (rst)        afr_q <= '0;
        else if (wr_en) afr_q <= wdata;
    end

    assign concur = afr_q[0];
    assign mf_sel = mf_sel_e'(afr_q[2:1]);
endmodule

// File: rtl/dca_mf_mux.sv
module dca_mf_mux
    import dca_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  mf_sel_e           sel,
    input  logic [NUM_CH-1:0] gpo_n,
    input  logic [NUM_CH-1:0] baud_n,
    input  logic [NUM_CH-1:0] rxr_n,
    output logic [NUM_CH-1:0] pin_n
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_pin
        assign pin_n[i] = mf_pick(sel, gpo_n[i], baud_n[i], rxr_n[i]);
    end
endmodule

// File: rtl/dual_uart_regctl.sv
module dual_uart_regctl
    import dca_pkg::*;
#(
    parameter int          NUM_CH = 2,
    parameter logic [7:0]  DEV_ID = 8'h02
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [2:0]                 cpu_addr,
    input  logic [$clog2(NUM_CH)-1:0]  cpu_chsel,
    input  logic                       cpu_wr,
    input  logic                       cpu_rd,
    input  logic [7:0]                 cpu_wdata,
    output logic [7:0]                 cpu_rdata,
    input  logic [NUM_CH-1:0]          ch_dlab,
    input  logic [NUM_CH-1:0]          ch_enh,
    input  logic [NUM_CH-1:0]          ch_divz,
    input  logic [8*NUM_CH-1:0]        ch_rdata,
    output logic [NUM_CH-1:0]          ch_we,
    output logic [NUM_CH-1:0]          ch_re,
    output logic [3:0]                 ch_reg,
    output logic [7:0]                 ch_wdata,
    input  logic [NUM_CH-1:0]          src_op2_n,
    input  logic [NUM_CH-1:0]          src_baud_n,
    input  logic [NUM_CH-1:0]          src_rxrdy_n,
    output logic [NUM_CH-1:0]          mf_n
);
    localparam int CH_W = $clog2(NUM_CH);

    dec_t       dec;
    logic       hit_altfn;
    logic       hit_ident;
    logic       local_hit;
    logic       altfn_wr;
    logic [2:0] afr_q;
    logic       concur;
    mf_sel_e    mf_sel;

    dca_decode u_dec (
        .addr (cpu_addr),
        .dlab (ch_dlab[cpu_chsel]),
        .enh  (ch_enh[cpu_chsel]),
        .divz (ch_divz[cpu_chsel]),
        .dec  (dec)
    );

    assign hit_altfn = dec.hit_altfn;
    assign hit_ident = dec.hit_ident;
    assign local_hit = hit_altfn | hit_ident;
    assign altfn_wr  = cpu_wr & hit_altfn;

    dca_altfn u_afr (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (altfn_wr),
        .wdata  (cpu_wdata[2:0]),
        .afr_q  (afr_q),
        .concur (concur),
        .mf_sel (mf_sel)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic picked;
        assign picked   = (cpu_chsel == CH_W'(i));
        assign ch_we[i] = cpu_wr & ~local_hit & (concur | picked);
        assign ch_re[i] = cpu_rd & ~local_hit & picked;
    end

    assign ch_reg   = dec.idx;
    assign ch_wdata = cpu_wdata;

    always_comb begin
        if (hit_altfn)      cpu_rdata = {5'b0, afr_q};
        else if (hit_ident) cpu_rdata = DEV_ID;
        else                cpu_rdata = ch_rdata[8*cpu_chsel +: 8];
    end

    dca_mf_mux #(.NUM_CH(NUM_CH)) u_mf (
        .sel    (mf_sel),
        .gpo_n  (src_op2_n),
        .baud_n (src_baud_n),
        .rxr_n  (src_rxrdy_n),
        .pin_n  (mf_n)
    );
endmodule

// File: rtl/dca_chk.sv
module dca_chk #(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_wr,
    input logic              cpu_rd,
    input logic [7:0]        cpu_wdata,
    input logic [NUM_CH-1:0] ch_we,
    input logic [NUM_CH-1:0] ch_re,
    input logic [NUM_CH-1:0] mf_n,
    input logic [2:0]        afr_q,
    input logic              altfn_wr,
    input logic              hit_altfn,
    input logic              hit_ident
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> afr_q == 3'd0);

    // R2
    single_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && !afr_q[0]) |-> $countones(ch_we) <= 1);

    // R3
    multi_write_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(ch_we) > 1) |-> afr_q[0]);

    // R4
    single_read_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_re));

    // R5
    altfn_update_chk: assert property (@(posedge clk) disable iff (rst)
        altfn_wr |=> afr_q == $past(cpu_wdata[2:0]));

    // R6
    mf_off_chk: assert property (@(posedge clk) disable iff (rst)
        (afr_q[2:1] == 2'd2) |-> mf_n == '1);

    // R8
    ident_no_we_chk: assert property (@(posedge clk) disable iff (rst)
        hit_ident |-> (ch_we == '0 && ch_re == '0));

    // R10
    altfn_local_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_altfn && (cpu_wr || cpu_rd)) |-> (ch_we == '0 && ch_re == '0));
endmodule

bind dual_uart_regctl dca_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .cpu_wdata (cpu_wdata),
    .ch_we     (ch_we),
    .ch_re     (ch_re),
    .mf_n      (mf_n),
    .afr_q     (afr_q),
    .altfn_wr  (altfn_wr),
    .hit_altfn (hit_altfn),
    .hit_ident (hit_ident)
);

// File: tb/dual_uart_regctl_bench.sv
module dual_uart_regctl_bench;
    localparam int NCH = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [2:0]       cpu_addr = '0;
    logic             cpu_chsel = 1'b0;
    logic             cpu_wr = 1'b0;
    logic             cpu_rd = 1'b0;
    logic [7:0]       cpu_wdata = '0;
    logic [7:0]       cpu_rdata;
    logic [NCH-1:0]   ch_dlab = '0;
    logic [NCH-1:0]   ch_enh = '0;
    logic [NCH-1:0]   ch_divz = '0;
    logic [8*NCH-1:0] ch_rdata = 16'hB5A3;
    logic [NCH-1:0]   ch_we;
    logic [NCH-1:0]   ch_re;
    logic [3:0]       ch_reg;
    logic [7:0]       ch_wdata;
    logic [NCH-1:0]   src_op2_n = 2'b10;
    logic [NCH-1:0]   src_baud_n = 2'b01;
    logic [NCH-1:0]   src_rxrdy_n = 2'b00;
    logic [NCH-1:0]   mf_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dual_uart_regctl u_dual_uart_regctl (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_chsel(cpu_chsel),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .ch_dlab(ch_dlab), .ch_enh(ch_enh),
        .ch_divz(ch_divz), .ch_rdata(ch_rdata), .ch_we(ch_we), .ch_re(ch_re),
        .ch_reg(ch_reg), .ch_wdata(ch_wdata), .src_op2_n(src_op2_n),
        .src_baud_n(src_baud_n), .src_rxrdy_n(src_rxrdy_n), .mf_n(mf_n)
    );

    // {chsel, dlab, enh, divz, addr[2:0], exp_idx[3:0], exp_we[1:0]}
    localparam int NVEC = 9;
    localparam logic [12:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 4'd3,  2'b01},  // R2 R9
        {1'b1, 1'b0, 1'b1, 1'b1, 3'd0, 4'd0,  2'b10},  // R2 R9
        {1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 4'd8,  2'b01},  // R9
        {1'b1, 1'b1, 1'b0, 1'b0, 3'd1, 4'd9,  2'b10},  // R9
        {1'b0, 1'b1, 1'b1, 1'b0, 3'd2, 4'd10, 2'b01},  // R7
        {1'b0, 1'b1, 1'b0, 1'b0, 3'd2, 4'd2,  2'b01},  // R7
        {1'b1, 1'b1, 1'b0, 1'b1, 3'd5, 4'd0,  2'b00},  // R8
        {1'b1, 1'b1, 1'b0, 1'b0, 3'd5, 4'd5,  2'b10},  // R8
        {1'b0, 1'b1, 1'b0, 1'b0, 3'd4, 4'd0,  2'b00}   // R10
    };

    task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic setup(input logic sel, input logic dlab, input logic [2:0] a,
                         input logic wr, input logic rd, input logic [7:0] d);
        @(negedge clk);
        cpu_chsel = sel;
        ch_dlab   = {NCH{dlab}};
        cpu_addr  = a;
        cpu_wr    = wr;
        cpu_rd    = rd;
        cpu_wdata = d;
        #1;
    endtask

    task automatic altfn_write(input logic sel, input logic [7:0] d);
        setup(sel, 1'b1, 3'd4, 1'b1, 1'b0, d);
        @(negedge clk);
        cpu_wr = 1'b0;
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(mf_n == src_op2_n, "R1 mf after reset", 16'(mf_n), 16'(src_op2_n));
        chk(ch_we == 2'b00, "R1 idle we", 16'(ch_we), 16'h0);
        setup(1'b0, 1'b1, 3'd4, 1'b0, 1'b1, 8'h00);
        chk(cpu_rdata == 8'h00, "R1 altfn reads zero", 16'(cpu_rdata), 16'h0);
        chk(ch_re == 2'b00, "R10 altfn read no re", 16'(ch_re), 16'h0);

        // decode table walked with single-channel writes
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            cpu_chsel = VEC[i][12];
            ch_dlab   = {NCH{VEC[i][11]}};
            ch_enh    = {NCH{VEC[i][10]}};
            ch_divz   = {NCH{VEC[i][9]}};
            cpu_addr  = VEC[i][8:6];
            cpu_wr    = 1'b1;
            cpu_rd    = 1'b0;
            cpu_wdata = 8'h00;
            #1;
            chk(ch_we == VEC[i][1:0], "R2/R7/R8/R9/R10 table we",
                16'(ch_we), 16'(VEC[i][1:0]));
            if (VEC[i][1:0] != 2'b00)
                chk(ch_reg == VEC[i][5:2], "R7/R9 table index",
                    16'(ch_reg), 16'(VEC[i][5:2]));
        end
        @(negedge clk);
        cpu_wr  = 1'b0;
        ch_enh  = '0;
        ch_divz = '0;

        // R5 write through channel B, reserved bits dropped
        altfn_write(1'b1, 8'hFE);
        setup(1'b0, 1'b1, 3'd4, 1'b0, 1'b1, 8'h00);
        chk(cpu_rdata == 8'h06, "R5 altfn readback", 16'(cpu_rdata), 16'h06);
        chk(mf_n == src_rxrdy_n, "R6 code 3", 16'(mf_n), 16'(src_rxrdy_n));
        altfn_write(1'b0, 8'h02);
        chk(mf_n == src_baud_n, "R6 code 1", 16'(mf_n), 16'(src_baud_n));
        altfn_write(1'b0, 8'h04);
        chk(mf_n == 2'b11, "R6 code 2 off", 16'(mf_n), 16'h3);
        altfn_write(1'b1, 8'h00);
        chk(mf_n == src_op2_n, "R6 code 0", 16'(mf_n), 16'(src_op2_n));

        // R3 concurrent write
        altfn_write(1'b0, 8'h01);
        setup(1'b1, 1'b0, 3'd3, 1'b1, 1'b0, 8'h5C);
        chk(ch_we == 2'b11, "R3 both we", 16'(ch_we), 16'h3);
        chk(ch_reg == 4'd3 && ch_wdata == 8'h5C, "R3 index and data",
            {4'h0, ch_reg, ch_wdata}, 16'h035C);

        // R4 reads steered in concurrent mode
        setup(1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 8'h00);
        chk(cpu_rdata == 8'hB5 && ch_re == 2'b10, "R4 read B",
            {6'h0, ch_re, cpu_rdata}, 16'h02B5);
        setup(1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 8'h00);
        chk(cpu_rdata == 8'hA3 && ch_re == 2'b01, "R4 read A",
            {6'h0, ch_re, cpu_rdata}, 16'h01A3);

        // R5 clear from channel B, then single write again (R2)
        altfn_write(1'b1, 8'h00);
        setup(1'b1, 1'b0, 3'd3, 1'b1, 1'b0, 8'h11);
        chk(ch_we == 2'b10, "R5 clear via B, R2 single", 16'(ch_we), 16'h2);

        // R8 identification register
        @(negedge clk);
        cpu_wr  = 1'b0;
        ch_divz = 2'b11;
        setup(1'b0, 1'b1, 3'd5, 1'b1, 1'b0, 8'hFF);
        chk(ch_we == 2'b00, "R8 ident write ignored", 16'(ch_we), 16'h0);
        setup(1'b0, 1'b1, 3'd5, 1'b0, 1'b1, 8'h00);
        chk(cpu_rdata == 8'h02 && ch_re == 2'b00, "R8 ident read",
            {6'h0, ch_re, cpu_rdata}, 16'h0002);
        setup(1'b0, 1'b1, 3'd4, 1'b0, 1'b1, 8'h00);
        chk(cpu_rdata == 8'h00, "R8 ident write left altfn", 16'(cpu_rdata), 16'h0);
        @(negedge clk);
        ch_divz = 2'b00;
        setup(1'b1, 1'b1, 3'd5, 1'b0, 1'b1, 8'h00);
        chk(cpu_rdata == 8'hB5 && ch_re == 2'b10 && ch_reg == 4'd5,
            "R8 divisor nonzero routes to channel",
            {2'h0, ch_re, ch_reg, cpu_rdata}, 16'h25B5);

        @(negedge clk);
        cpu_rd = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule